// File: doc/BRIEF.md
# Per-Lane Data Mask Pipeline for a Synchronous DRAM Data Path

This block turns the byte-lane mask inputs of a synchronous DRAM data path into two sets of per-lane enables. One set is the output enables for the read data drivers. The other is the write enables into storage. The mask has a different latency in each direction. A mask bit sampled on a read drives the lane's output enable low a fixed number of clocks later, two by default. The same bit presented during a write blocks that lane's write beat in the same clock, with no delay.

The command decoder supplies three flags. The read-beat flag says a read data beat belongs on the pins in this cycle. The write-phase flag says the device is accepting write data. The strobe marks each write beat. A write can interrupt a read burst that still has beats in flight. In that case the controller raises the mask ahead of the write so that no read driver is still on the bus. The block also has a built-in guard that turns the drivers off whenever the write phase is active. Each byte lane is masked on its own.

Top module: `dqm_mask_pipe`

## Requirements
- R1: While `rst_n` is low, `oe` and `we` are all zero. Reset fills the read mask history with "masked". After release, `oe` therefore stays low until a mask value sampled after release has passed through the whole read delay.
- R2: With reset released, `rd_vld` high and `wr_active` low, `oe[i]` in cycle t equals the inverse of `dqm[i]` as sampled in cycle t-2. A raised mask bit has no effect on `oe` in the cycle it is raised or in the cycle after.
- R3: When `rd_vld` is low, `oe` is all zero whatever the value or history of `dqm`.
- R4: When `wr_active` and `wr_strobe` are both high, `we[i]` in that same cycle is high exactly when `dqm[i]` is low.
- R5: When `wr_active` or `wr_strobe` is low, `we` is all zero.
- R6: Whenever `wr_active` is high, `oe` is all zero, including the cycles where a read-to-write interrupt leaves `rd_vld` still high.
- R7: Each lane depends only on its own mask bit. Setting one bit of `dqm` changes only that lane's `oe` and `we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dqm | input | LANES | Mask bit per byte lane, 1 = masked |
| rd_vld | input | 1 | A read data beat belongs on the pins this cycle |
| wr_active | input | 1 | Write data phase is active |
| wr_strobe | input | 1 | A write data beat is presented this cycle |
| oe | output | LANES | Per-lane read data output enable |
| we | output | LANES | Per-lane write enable into storage |

## Verification
Most of the state in this block is the read mask delay line. A wrong value in one of its stages shows on `oe` for the affected lane in the cycle that stage reaches the output. That is at most two cycles after the fault, and only while a read beat is valid. The bench therefore keeps `rd_vld` high for long random stretches and compares `oe` in every cycle. A wrong reset value shows in the first cycle after release. The write path holds no state by default, so any fault in it shows on `we` in the same cycle as the strobe. The interrupt cases with a trailing read beat show any leak in the contention guard at once.

// File: rtl/dqm_pkg.sv
package dqm_pkg;

   // Direction the data bus is claimed for in the current cycle.
   // Write wins over read so trailing read beats never fight write data.
   typedef enum logic [1:0] {
      DIR_IDLE  = 2'd0,
      DIR_READ  = 2'd1,
      DIR_WRITE = 2'd2
   } bus_dir_e;

   function automatic bus_dir_e pick_dir(input logic rd, input logic wr);
      if (wr)
         return DIR_WRITE;
      else if (rd)
         return DIR_READ;
      else
         return DIR_IDLE;
   endfunction

   localparam int MAX_RD_LAT = 8;
   localparam int MAX_WR_LAT = 1;

endpackage

// File: rtl/dqm_delay_line.sv
module dqm_delay_line #(
   parameter int              WIDTH   = 4,
   parameter int              DEPTH   = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("dqm_delay_line: WIDTH must be at least 1");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("dqm_delay_line: DEPTH must be at least 1");
   end

   logic [WIDTH-1:0] stage [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stage[0] <= RST_VAL;
      else
         stage[0] <= d;
   end

   for (genvar s = 1; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage[s] <= RST_VAL;
         else
            stage[s] <= stage[s-1];
      end
   end

   assign q = stage[DEPTH-1];

endmodule

// File: rtl/dqm_read_gate.sv
module dqm_read_gate
   import dqm_pkg::*;
#(
   parameter int LANES = 4,
   parameter bit GUARD = 1'b1
) (
   input  logic             rst_n,
   input  bus_dir_e         dir,
   input  logic             rd_vld,
   input  logic [LANES-1:0] dqm_late,
   output logic [LANES-1:0] oe
);

   logic beat_ok;

   if (GUARD) begin : g_guarded
      // Drivers may turn on only when the bus is claimed for a read.
      assign beat_ok = rst_n && (dir == DIR_READ);
   end else begin : g_plain
      logic dir_unused;
      assign dir_unused = (dir == DIR_IDLE);
      assign beat_ok    = rst_n && rd_vld && (dir_unused || !dir_unused);
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign oe[l] = beat_ok && !dqm_late[l];
   end

endmodule

// File: rtl/dqm_write_mask.sv
module dqm_write_mask
   import dqm_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             rst_n,
   input  bus_dir_e         dir,
   input  logic             wr_strobe,
   input  logic [LANES-1:0] dqm_wr,
   output logic [LANES-1:0] we
);

   logic beat_take;

   assign beat_take = rst_n && (dir == DIR_WRITE) && wr_strobe;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign we[l] = beat_take && !dqm_wr[l];
   end

endmodule

// File: rtl/dqm_mask_pipe.sv
module dqm_mask_pipe
   import dqm_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int RD_LAT = 2,
   parameter int WR_LAT = 0,
   parameter bit GUARD  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] dqm,
   input  logic             rd_vld,
   input  logic             wr_active,
   input  logic             wr_strobe,
   output logic [LANES-1:0] oe,
   output logic [LANES-1:0] we
);

   localparam logic [LANES-1:0] ALL_MASKED = {LANES{1'b1}};

   if (LANES < 1 || LANES > 64) begin : g_bad_lanes
      $error("dqm_mask_pipe: LANES out of range");
   end
   if (RD_LAT < 0 || RD_LAT > MAX_RD_LAT) begin : g_bad_rd
      $error("dqm_mask_pipe: RD_LAT out of range");
   end
   if (WR_LAT < 0 || WR_LAT > MAX_WR_LAT) begin : g_bad_wr
      $error("dqm_mask_pipe: WR_LAT out of range");
   end

   bus_dir_e         dir;
   logic [LANES-1:0] dqm_rd_late;
   logic [LANES-1:0] dqm_wr_late;

   assign dir = pick_dir(rd_vld, wr_active);

   // Read side: the mask lands on the drivers RD_LAT clocks after sampling.
   if (RD_LAT == 0) begin : g_rd_direct
      assign dqm_rd_late = dqm;
   end else begin : g_rd_delay
      dqm_delay_line #(
         .WIDTH   (LANES),
         .DEPTH   (RD_LAT),
         .RST_VAL (ALL_MASKED)
      ) rd_dly_i (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (dqm),
         .q     (dqm_rd_late)
      );
   end

   // Write side: zero latency by default, optional one-clock variant.
   if (WR_LAT == 0) begin : g_wr_direct
      assign dqm_wr_late = dqm;
   end else begin : g_wr_delay
      dqm_delay_line #(
         .WIDTH   (LANES),
         .DEPTH   (WR_LAT),
         .RST_VAL (ALL_MASKED)
      ) wr_dly_i (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (dqm),
         .q     (dqm_wr_late)
      );
   end

   dqm_read_gate #(
      .LANES (LANES),
      .GUARD (GUARD)
   ) rd_gate_i (
      .rst_n    (rst_n),
      .dir      (dir),
      .rd_vld   (rd_vld),
      .dqm_late (dqm_rd_late),
      .oe       (oe)
   );

   dqm_write_mask #(
      .LANES (LANES)
   ) wr_mask_i (
      .rst_n     (rst_n),
      .dir       (dir),
      .wr_strobe (wr_strobe),
      .dqm_wr    (dqm_wr_late),
      .we        (we)
   );

endmodule

// File: rtl/dqm_mask_pipe_chk.sv
module dqm_mask_pipe_chk #(
   parameter int LANES  = 4,
   parameter int RD_LAT = 2,
   parameter int WR_LAT = 0,
   parameter bit GUARD  = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LANES-1:0] dqm,
   input logic             rd_vld,
   input logic             wr_active,
   input logic             wr_strobe,
   input logic [LANES-1:0] oe,
   input logic [LANES-1:0] we
);

   // Cycles since reset release, saturating, to keep $past inside history.
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_rst <= 2'd0;
      else if (since_rst != 2'd3)
         since_rst <= since_rst + 2'd1;
   end

   p_quiet_in_reset_r1: assert property (@(posedge clk)
      !rst_n |-> (oe == '0 && we == '0));

   if (RD_LAT == 2 && GUARD) begin : g_lat2
      p_read_mask_two_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 2'd2 && rd_vld && !wr_active) |-> (oe == ~$past(dqm, 2)));
   end

   p_oe_needs_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_vld |-> (oe == '0));

   if (WR_LAT == 0) begin : g_wr0
      p_write_mask_same_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_active && wr_strobe) |-> ((we & dqm) == '0 && (we | dqm) == '1));
   end

   p_we_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_active && wr_strobe) |-> (we == '0));

   if (GUARD) begin : g_guard
      p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
         wr_active |-> (oe == '0));
   end

endmodule

bind dqm_mask_pipe dqm_mask_pipe_chk #(
   .LANES  (LANES),
   .RD_LAT (RD_LAT),
   .WR_LAT (WR_LAT),
   .GUARD  (GUARD)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .dqm       (dqm),
   .rd_vld    (rd_vld),
   .wr_active (wr_active),
   .wr_strobe (wr_strobe),
   .oe        (oe),
   .we        (we)
);

// File: tb/dqm_mask_pipe_tb_top.sv
module dqm_mask_pipe_tb_top;

   localparam int LANES = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [LANES-1:0] dqm = '0;
   logic             rd_vld = 1'b0;
   logic             wr_active = 1'b0;
   logic             wr_strobe = 1'b0;
   logic [LANES-1:0] oe;
   logic [LANES-1:0] we;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   dqm_mask_pipe #(
      .LANES  (LANES),
      .RD_LAT (2),
      .WR_LAT (0),
      .GUARD  (1'b1)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .dqm       (dqm),
      .rd_vld    (rd_vld),
      .wr_active (wr_active),
      .wr_strobe (wr_strobe),
      .oe        (oe),
      .we        (we)
   );

   // Bench model of the mask history seen by the read drivers (R1, R2).
   logic [LANES-1:0] h1, h2;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h1 <= '1;
         h2 <= '1;
      end else begin
         h2 <= h1;
         h1 <= dqm;
      end
   end

   function automatic logic [LANES-1:0] exp_oe(input logic rst, rd, wr,
                                               input logic [LANES-1:0] hist);
      return (rst && rd && !wr) ? ~hist : '0;
   endfunction

   function automatic logic [LANES-1:0] exp_we(input logic rst, wr, st,
                                               input logic [LANES-1:0] d);
      return (rst && wr && st) ? ~d : '0;
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic step(input logic [LANES-1:0] d, input logic rd, input logic wr,
                       input logic st, input string tg);
      string to, tw;
      @(posedge clk);
      #1;
      dqm = d; rd_vld = rd; wr_active = wr; wr_strobe = st;
      @(negedge clk);
      if (tg != "") begin
         to = tg; tw = tg;
      end else begin
         to = !rst_n ? "R1" : (!rd ? "R3" : (wr ? "R6" : "R2"));
         tw = !rst_n ? "R1" : (!(wr && st) ? "R5" : "R4");
      end
      check(to, "oe", oe, exp_oe(rst_n, rd, wr, h2));
      check(tw, "we", we, exp_we(rst_n, wr, st, d));
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0d9a));

      // R1: outputs silent while reset is held, even with every request up.
      for (int i = 0; i < 3; i++) step('0, 1'b1, 1'b1, 1'b1, "R1");
      step('0, 1'b1, 1'b0, 1'b0, "R1");
      @(negedge clk);
      rst_n = 1'b1;
      // R1: the first beat after release still sees the reset "masked" history.
      step('0, 1'b1, 1'b0, 1'b0, "R1");
      step('0, 1'b1, 1'b0, 1'b0, "R2");
      step('0, 1'b1, 1'b0, 1'b0, "R2");

      // R2: a mask pulse in a read burst reaches oe exactly two clocks later.
      step(4'hF, 1'b1, 1'b0, 1'b0, "R2");
      step(4'h0, 1'b1, 1'b0, 1'b0, "R2");
      step(4'h0, 1'b1, 1'b0, 1'b0, "R2");
      step(4'h5, 1'b1, 1'b0, 1'b0, "R2");
      step(4'h0, 1'b1, 1'b0, 1'b0, "R2");
      step(4'h0, 1'b1, 1'b0, 1'b0, "R2");

      // R3: no beat, no drive, with mask low throughout.
      for (int i = 0; i < 4; i++) step(4'h0, 1'b0, 1'b0, 1'b0, "R3");

      // R7: one mask bit per lane, walking; other lanes unaffected.
      for (int l = 0; l < LANES; l++) step(4'(1 << l), 1'b1, 1'b0, 1'b0, "R7");
      step(4'h0, 1'b1, 1'b0, 1'b0, "R7");
      step(4'h0, 1'b1, 1'b0, 1'b0, "R7");
      for (int l = 0; l < LANES; l++) step(4'(1 << l), 1'b0, 1'b1, 1'b1, "R7");

      // R6: read burst cut by a write with trailing read beats still flagged.
      step(4'h0, 1'b1, 1'b0, 1'b0, "");
      step(4'hF, 1'b1, 1'b0, 1'b0, "");
      step(4'h2, 1'b1, 1'b1, 1'b1, "R6");
      step(4'h0, 1'b1, 1'b1, 1'b1, "R6");
      step(4'h0, 1'b0, 1'b1, 1'b1, "R4");
      step(4'h9, 1'b0, 1'b1, 1'b1, "R4");
      step(4'h0, 1'b0, 1'b1, 1'b0, "R5");
      step(4'h0, 1'b0, 1'b0, 1'b1, "R5");

      // Random mix: long read stretches, write phases, sparse strobes.
      for (int i = 0; i < 4000; i++) begin
         logic [LANES-1:0] d;
         logic rd, wr, st;
         d  = LANES'($urandom);
         if (($urandom % 4) == 0) d = '0;
         rd = ($urandom % 8) != 0;
         wr = ($urandom % 4) == 0;
         st = ($urandom % 3) != 0;
         step(d, rd, wr, st, "");
      end

      // R1 again: a mid-run reset re-fills the history with "masked".
      @(negedge clk);
      rst_n = 1'b0;
      step(4'h0, 1'b1, 1'b1, 1'b1, "R1");
      @(negedge clk);
      rst_n = 1'b1;
      step(4'h0, 1'b1, 1'b0, 1'b0, "R1");
      step(4'h0, 1'b1, 1'b0, 1'b0, "R2");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule